// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers seven interrupt request lines and forwards at most one of them to a CPU core. A request takes part in arbitration only when its own enable bit and the global enable bit are both set. Among the eligible requests a hard-wired ranking picks one. The block then offers that source's entry address on a registered vector output and raises a valid flag. The vector and the source number stay frozen until the CPU acknowledges. The acknowledge is passed back to the winning source as a one-cycle pulse, so that the source can clear its own flag.

The system has one interrupt level. After an acknowledge the controller is busy, and it offers nothing more until the CPU signals return-from-interrupt. Requests that lost arbitration, or that arrive while a handler runs, are not lost. They are offered once the controller is idle again, as long as their request lines stay high.

The ranking does not follow the order of the vector addresses. The PWM source ranks fourth, yet its entry address is the highest of the seven.

Top module: `irq_fixprio_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, vec_valid is 0 and src_ack is all zero. Reset clears every enable bit, including the global one, so no request is offered until software writes the enable register.
- R2: A source takes part in arbitration only when its request bit, its enable bit and the global enable bit are all 1. Request and enable bit i belong to priority index i.
- R3: The priority index runs from highest to lowest priority: 0 external line 0, 1 timer 0 overflow, 2 external line 1, 3 PWM, 4 bus timer, 5 I2C serial, 6 ADC. In idle, the eligible source with the lowest index wins.
- R4: Each priority index maps to a fixed entry address. Index 0 gives 0x0003, 1 gives 0x000B, 2 gives 0x0013, 3 gives 0x0033, 4 gives 0x001B, 5 gives 0x0023 and 6 gives 0x002B. vec_src carries the priority index of the offer.
- R5: From the cycle in which vec_valid rises until the acknowledge is taken, vec_valid stays 1 and vec_addr and vec_src do not change, even if the requests or enables change.
- R6: When cpu_ack is 1 at a clock edge while vec_valid is 1, vec_valid is 0 after that edge. For exactly one cycle, src_ack then carries a single 1 at the bit of vec_src. Other eligible requests stay pending and are offered later.
- R7: From an accepted acknowledge until a return-from-interrupt (reti high at a clock edge), no vector is offered. The next offer can appear at the clock edge after the reti edge.
- R8: cpu_ack while no vector is offered produces no src_ack pulse. reti while not busy is ignored: a pending offer stays valid and unchanged.
- R9: A write (en_we high) loads en_wdata. Bits 0 to 6 are the per-source enables by priority index, and bit 7 is the global enable. Arbitration uses the new value from the edge after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Request level per source, by priority index |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable write data: bits 6:0 per source, bit 7 global |
| cpu_ack | input | 1 | CPU accepts the offered vector |
| reti | input | 1 | CPU return-from-interrupt |
| vec_valid | output | 1 | A vector is being offered |
| vec_addr | output | 16 | Entry address of the offered source |
| vec_src | output | 3 | Priority index of the offered source |
| src_ack | output | 7 | One-cycle acknowledge pulse to the winning source |

## Verification
The assertions assume that a source keeps its request high until its acknowledge pulse. They also assume that the CPU issues reti only to end a handler it has entered. The checks on arbitration compare a new offer with the requests and effective enables of the cycle before, which holds only because the bench changes requests on the falling edge and never in the same cycle as an offer. The bench models each source as clearing its own request bit right after its pulse. It raises cpu_ack and reti for single cycles only. Extra acknowledges and returns are sent at idle or offering moments on purpose, to exercise the ignore rules.

// File: rtl/irq_fixprio_pkg.sv
package irq_fixprio_pkg;

  localparam int N_SRC = 7;
  localparam int SRC_W = $clog2(N_SRC);

  // priority index: lower value wins
  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0   = 3'd0,
    SRC_TMR0   = 3'd1,
    SRC_EXT1   = 3'd2,
    SRC_PWM    = 3'd3,
    SRC_BUSTMR = 3'd4,
    SRC_I2C    = 3'd5,
    SRC_ADC    = 3'd6
  } src_id_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2
  } ctl_state_t;

  // slot number in the vector table, independent of the ranking
  function automatic logic [SRC_W-1:0] vec_slot(input logic [SRC_W-1:0] s);
    logic [SRC_W-1:0] r;
    case (src_id_t'(s))
      SRC_EXT0:   r = 3'd0;
      SRC_TMR0:   r = 3'd1;
      SRC_EXT1:   r = 3'd2;
      SRC_BUSTMR: r = 3'd3;
      SRC_I2C:    r = 3'd4;
      SRC_ADC:    r = 3'd5;
      SRC_PWM:    r = 3'd6;
      default:    r = 3'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N:0]   wdata,
  output logic [N-1:0] en_eff
);

  logic [N-1:0] en_q;
  logic         gie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (we) begin
      en_q  <= wdata[N-1:0];
      gie_q <= wdata[N];
    end
  end

  assign en_eff = en_q & {N{gie_q}};

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 7,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N-1:0] blk;
  logic [N-1:0] grant;

  assign blk[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i] = elig[i] & ~blk[i];
    if (i < N - 1) begin : g_next
      assign blk[i+1] = blk[i] | elig[i];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign any = |elig;

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
  import irq_fixprio_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [SRC_W-1:0]  src,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] slot_w;

  assign slot_w = ADDR_W'(vec_slot(src));
  assign addr   = ADDR_W'(VEC_BASE) + slot_w * ADDR_W'(VEC_STRIDE);

endmodule

// File: rtl/irq_fixprio_ctrl.sv
module irq_fixprio_ctrl
  import irq_fixprio_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              en_we,
  input  logic [N_SRC:0]    en_wdata,
  input  logic              cpu_ack,
  input  logic              reti,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [SRC_W-1:0]  vec_src,
  output logic [N_SRC-1:0]  src_ack
);

  logic [N_SRC-1:0]  en_eff;
  logic [N_SRC-1:0]  elig;
  logic              pick_any;
  logic [SRC_W-1:0]  pick_idx;
  logic [ADDR_W-1:0] pick_addr;
  ctl_state_t        state;
  logic              busy;

  irq_en_reg #(.N(N_SRC)) u_en (
    .clk    (clk),
    .rst    (rst),
    .we     (en_we),
    .wdata  (en_wdata),
    .en_eff (en_eff)
  );

  assign elig = irq_req & en_eff;

  irq_prio_pick #(.N(N_SRC), .IW(SRC_W)) u_pick (
    .elig (elig),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  irq_vec_map #(
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_map (
    .src  (pick_idx),
    .addr (pick_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      vec_src   <= '0;
      src_ack   <= '0;
    end else begin
      src_ack <= '0;
      case (state)
        ST_IDLE: begin
          if (pick_any) begin
            vec_valid <= 1'b1;
            vec_addr  <= pick_addr;
            vec_src   <= pick_idx;
            state     <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (cpu_ack) begin
            vec_valid <= 1'b0;
            src_ack   <= N_SRC'(1) << vec_src;
            state     <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (reti) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/irq_fixprio_chk.sv
module irq_fixprio_chk #(
  parameter int N  = 7,
  parameter int SW = 3,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  irq_req,
  input logic          cpu_ack,
  input logic          vec_valid,
  input logic [AW-1:0] vec_addr,
  input logic [SW-1:0] vec_src,
  input logic [N-1:0]  src_ack,
  input logic          busy,
  input logic [N-1:0]  en_eff
);

  logic [N-1:0] hi_mask;
  assign hi_mask = (N'(1) << vec_src) - N'(1);

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vec_valid && src_ack == '0)); // R1

  AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> ($past(irq_req & en_eff) & (N'(1) << vec_src)) != '0); // R2

  AST_OFFER_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> ($past(irq_req & en_eff) & hi_mask) == '0); // R3

  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !cpu_ack) |=> (vec_valid && $stable(vec_addr) && $stable(vec_src))); // R5

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ack)); // R6

  AST_ACK_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && cpu_ack) |=> (!vec_valid && src_ack == (N'(1) << vec_src))); // R6

  AST_ACK_CAUSED: assert property (@(posedge clk) disable iff (rst)
    (src_ack != '0) |-> $past(vec_valid && cpu_ack)); // R8

  AST_NO_OFFER_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !vec_valid); // R7

  AST_RISE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> !$past(busy)); // R7

endmodule

bind irq_fixprio_ctrl irq_fixprio_chk #(
  .N  (irq_fixprio_pkg::N_SRC),
  .SW (irq_fixprio_pkg::SRC_W),
  .AW (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_req   (irq_req),
  .cpu_ack   (cpu_ack),
  .vec_valid (vec_valid),
  .vec_addr  (vec_addr),
  .vec_src   (vec_src),
  .src_ack   (src_ack),
  .busy      (busy),
  .en_eff    (en_eff)
);

// File: tb/irq_fixprio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fixprio_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  irq_req = '0;
  logic        en_we = 1'b0;
  logic [7:0]  en_wdata = '0;
  logic        cpu_ack = 1'b0;
  logic        reti = 1'b0;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic [2:0]  vec_src;
  logic [6:0]  src_ack;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_fixprio_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .en_we(en_we), .en_wdata(en_wdata),
    .cpu_ack(cpu_ack), .reti(reti), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .vec_src(vec_src), .src_ack(src_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < 7; i++) if (v[i]) return i;
    return -1;
  endfunction

  // R4 table
  function automatic int exp_vec(input int idx);
    case (idx)
      0: return 'h0003;
      1: return 'h000B;
      2: return 'h0013;
      3: return 'h0033;
      4: return 'h001B;
      5: return 'h0023;
      6: return 'h002B;
      default: return -1;
    endcase
  endfunction

  task automatic wr_en(input logic [7:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    @(negedge clk);
    @(negedge clk);
    chk(tag, int'(vec_valid), 0);
  endtask

  // expects an offer at the next edge, acknowledges it, returns
  task automatic serve(input int idx, input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 valid"}, int'(vec_valid), 1);
    chk({tag, " R3 src"}, int'(vec_src), idx);
    chk({tag, " R4 addr"}, int'(vec_addr), exp_vec(idx));
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    chk({tag, " R6 ack"}, int'(src_ack), 1 << idx);
    chk({tag, " R6 drop"}, int'(vec_valid), 0);
    irq_req[idx] = 1'b0;
    @(negedge clk);
    chk({tag, " R6 pulse"}, int'(src_ack), 0);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(vec_valid), 0);
    chk("R1 reset ack", int'(src_ack), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post reset valid", int'(vec_valid), 0);
    irq_req = 7'h7F;
    expect_none("R1 enables clear after reset");

    // R9: write lands at edge E; offer not at E, but at E+1
    en_we = 1'b1; en_wdata = 8'h81;
    @(negedge clk);
    en_we = 1'b0;
    chk("R9 not before effect", int'(vec_valid), 0);
    @(negedge clk);
    chk("R9 after effect", int'(vec_valid), 1);
    chk("R9 src", int'(vec_src), 0);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    irq_req = '0;
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;

    // R3 R4 sweep over all request patterns
    wr_en(8'hFF);
    for (int p = 1; p < 128; p++) begin
      irq_req = 7'(p);
      serve(lowest(p), "R3 sweep");
      irq_req = '0;
    end

    // R2 sweep over all enable patterns
    for (int e = 0; e < 128; e++) begin
      irq_req = '0;
      wr_en({1'b1, 7'(e)});
      irq_req = 7'h7F;
      if (e == 0) expect_none("R2 all masked");
      else serve(lowest(e), "R2 enable sweep");
      irq_req = '0;
    end
    wr_en(8'h7F);
    irq_req = 7'h7F;
    expect_none("R2 global off");
    irq_req = '0;
    wr_en(8'h88);
    irq_req = 7'h7F;
    serve(3, "R2 global on PWM only");
    irq_req = '0;

    // R6 pending requests served in rank order
    wr_en(8'hFF);
    irq_req = 7'b0001001;
    serve(0, "R6 pending first");
    serve(3, "R6 pending second");
    irq_req = 7'h7F;
    for (int i = 0; i < 7; i++) serve(i, "R6 chain");

    // R7 busy blocks new offers until reti
    irq_req = 7'b0000011;
    @(posedge clk);
    @(negedge clk);
    chk("R7 first offer", int'(vec_src), 0);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    irq_req[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 no offer while busy", int'(vec_valid), 0);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    @(negedge clk);
    chk("R8 ack while busy ignored", int'(src_ack), 0);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    chk("R7 reti edge no offer yet", int'(vec_valid), 0);
    @(negedge clk);
    chk("R7 offer after reti", int'(vec_valid), 1);
    chk("R7 offer src", int'(vec_src), 1);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    irq_req = '0;
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;

    // R5 offer frozen while a higher request arrives
    irq_req = 7'b1000000;
    @(posedge clk);
    @(negedge clk);
    chk("R5 initial src", int'(vec_src), 6);
    irq_req[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 held valid", int'(vec_valid), 1);
    chk("R5 held src", int'(vec_src), 6);
    chk("R5 held addr", int'(vec_addr), 'h002B);
    // R8 reti while offering is ignored
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    @(negedge clk);
    chk("R8 reti ignored valid", int'(vec_valid), 1);
    chk("R8 reti ignored src", int'(vec_src), 6);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    chk("R5 ack goes to frozen src", int'(src_ack), 7'b1000000);
    irq_req[6] = 1'b0;
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    serve(0, "R5 later");

    // R8 ack in idle produces nothing
    irq_req = '0;
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    chk("R8 idle ack no pulse", int'(src_ack), 0);
    @(negedge clk);
    chk("R8 idle ack no valid", int'(vec_valid), 0);

    summary();
    $finish;
  end

endmodule